// File: doc/BRIEF.md
# Embedded Video Timing Code Decoder with Single-Error Correction

This block sits on an 8-bit 4:2:2 video sample stream that carries its synchronisation inside the data. It looks for the four-sample timing code that marks the start or the end of active video. The first three samples of the code are a fixed preamble: all ones, then all zeros, then all zeros. The fourth sample is a status word. That word holds the field flag, the vertical blanking flag and the horizontal flag, together with four protection bits.

The decoder checks the protection bits against the three flags. It repairs any single-bit error. When it sees more than one error, it marks the word as uncorrectable and passes the received flag bits through unchanged. It reports each code with a one-cycle strobe. It keeps the most recent flags on its outputs until the next code arrives. A flag tells whether the code marked start or end of active video. One of two status strobes reports whether a repair was made or the word could not be trusted.

A four-state machine tracks the preamble. ST_HUNT moves to ST_ONES on an all-ones sample. ST_ONES moves to ST_ZERO1 on an all-zeros sample, stays in ST_ONES on another all-ones sample, and otherwise returns to ST_HUNT. ST_ZERO1 moves to ST_ZERO2 on all zeros, goes to ST_ONES on all ones, and otherwise returns to ST_HUNT. In ST_ZERO2 the next valid sample is decoded as the status word. The machine then goes back to ST_HUNT, or to ST_ONES if that sample was all ones. Samples with the valid input low change no state.

Top module: `vid_trc_decode`

## Requirements
- R1: A status word is decoded only when it is the valid sample that directly follows valid samples 0xFF, 0x00, 0x00 in that order. Samples with smp_vld low are skipped and do not break the sequence. Any other valid sample breaks the preamble, and no code is reported.
- R2: Status word layout: bit 7 is always 1, F is bit 6, V is bit 5, H is bit 4, and the protection bits are bit 3 = V^H, bit 2 = F^H, bit 1 = F^V, bit 0 = F^V^H.
- R3: An error-free status word drives code_vld high for exactly one cycle, the cycle after the word is sampled. fld, vblk and hsync then equal F, V and H, and both status strobes stay low.
- R4: A status word with exactly one of F, V or H inverted is reported with that flag restored and fix_strobe high.
- R5: A status word with exactly one protection bit inverted is reported with F, V and H as received and fix_strobe high.
- R6: A status word with two bits inverted among bits 6..0 is reported with bad_strobe high, and fld, vblk and hsync equal to the received bits 6, 5 and 4.
- R7: A status word whose bit 7 is 0 is reported with bad_strobe high and the received bits 6, 5 and 4 passed through.
- R8: is_eav equals the reported H flag: 1 marks end of active video, 0 marks start.
- R9: After reset the flags are 0. fld, vblk and hsync change only in a cycle where code_vld is high, and hold their value otherwise.
- R10: fix_strobe and bad_strobe are never high together, and neither is high without code_vld.
- R11: Extra 0xFF samples before the two 0x00 samples (for example 0xFF, 0xFF, 0x00, 0x00) still form a valid preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample qualifier |
| smp_data | input | 8 | Video sample |
| code_vld | output | 1 | One-cycle pulse per decoded code |
| fld | output | 1 | Field flag from the last code |
| vblk | output | 1 | Vertical blanking flag from the last code |
| hsync | output | 1 | Horizontal flag from the last code |
| is_eav | output | 1 | Last code marked end of active video |
| fix_strobe | output | 1 | Last code had one error, which was corrected |
| bad_strobe | output | 1 | Last code was uncorrectable; raw flags passed |

## Verification
The bench walks every single-bit flip of the status word. A decoder with a wrong syndrome table would restore the wrong flag, or would report a parity-only flip as uncorrectable. Double flips that pair a flag with a protection bit come next. A lookup table that is too generous would "correct" these words into wrong flags when it should raise bad_strobe. Preambles are also fed with invalid gap cycles, with a leading repeated 0xFF, and broken in the middle. A sequencer that resets on a gap, or that does not re-arm on 0xFF, would drop codes or invent them. A bare status word without a preamble is also sent. It checks that the flags hold their value instead of following stray data.

// File: rtl/vid_trc_pkg.sv
package vid_trc_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_ONES,
        ST_ZERO1,
        ST_ZERO2
    } trc_state_e;

    typedef enum logic [1:0] {
        CHK_CLEAN,
        CHK_FIXED,
        CHK_BAD
    } trc_chk_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trc_flags_t;

    localparam int unsigned STATUS_W = 8;

endpackage

// File: rtl/vid_trc_seq.sv
module vid_trc_seq
    import vid_trc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    output logic          word_hit
);
    localparam logic [DW-1:0] ALL_ONES  = '1;
    localparam logic [DW-1:0] ALL_ZEROS = '0;

    trc_state_e state_q, state_d;
    logic       is_ones, is_zeros;

    assign is_ones  = (smp_data == ALL_ONES);
    assign is_zeros = (smp_data == ALL_ZEROS);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (smp_vld) begin
            unique case (state_q)
                ST_HUNT:  state_d = is_ones ? ST_ONES : ST_HUNT;
                ST_ONES:  state_d = is_zeros ? ST_ZERO1 : (is_ones ? ST_ONES : ST_HUNT);
                ST_ZERO1: state_d = is_zeros ? ST_ZERO2 : (is_ones ? ST_ONES : ST_HUNT);
                ST_ZERO2: state_d = is_ones ? ST_ONES : ST_HUNT;
                default:  state_d = ST_HUNT;
            endcase
        end
    end

    assign word_hit = smp_vld && (state_q == ST_ZERO2);

endmodule

// File: rtl/vid_trc_fix.sv
module vid_trc_fix
    import vid_trc_pkg::*;
(
    input  logic [STATUS_W-1:0] word,
    output trc_flags_t          flags,
    output trc_chk_e            chk
);
    trc_flags_t raw;
    logic [3:0] par_exp;
    logic [3:0] syn;

    assign raw     = '{f: word[6], v: word[5], h: word[4]};
    assign par_exp = {raw.v ^ raw.h, raw.f ^ raw.h, raw.f ^ raw.v, raw.f ^ raw.v ^ raw.h};
    assign syn     = par_exp ^ word[3:0];

    always_comb begin
        flags = raw;
        chk   = CHK_BAD;
        if (word[7]) begin
            case (syn)
                4'b0000: chk = CHK_CLEAN;
                4'b0111: begin flags.f = ~raw.f; chk = CHK_FIXED; end
                4'b1011: begin flags.v = ~raw.v; chk = CHK_FIXED; end
                4'b1101: begin flags.h = ~raw.h; chk = CHK_FIXED; end
                4'b1000, 4'b0100,
                4'b0010, 4'b0001: chk = CHK_FIXED;
                default: chk = CHK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/vid_trc_decode.sv
module vid_trc_decode
    import vid_trc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    output logic          code_vld,
    output logic          fld,
    output logic          vblk,
    output logic          hsync,
    output logic          is_eav,
    output logic          fix_strobe,
    output logic          bad_strobe
);
    localparam int unsigned TOP = DW - 1;

    logic       word_hit;
    trc_flags_t fixed;
    trc_chk_e   chk;

    vid_trc_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .word_hit (word_hit)
    );

    vid_trc_fix u_fix (
        .word  (smp_data[TOP -: STATUS_W]),
        .flags (fixed),
        .chk   (chk)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_vld   <= 1'b0;
            fix_strobe <= 1'b0;
            bad_strobe <= 1'b0;
            fld        <= 1'b0;
            vblk       <= 1'b0;
            hsync      <= 1'b0;
        end else begin
            code_vld   <= word_hit;
            fix_strobe <= word_hit && (chk == CHK_FIXED);
            bad_strobe <= word_hit && (chk == CHK_BAD);
            if (word_hit) begin
                fld   <= fixed.f;
                vblk  <= fixed.v;
                hsync <= fixed.h;
            end
        end
    end

    assign is_eav = hsync;

endmodule

// File: rtl/vid_trc_chk.sv
module vid_trc_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic [DW-1:0] smp_data,
    input logic          code_vld,
    input logic          fld,
    input logic          vblk,
    input logic          hsync,
    input logic          fix_strobe,
    input logic          bad_strobe
);
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fix_strobe && bad_strobe));

    p_strobe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_strobe || bad_strobe) |-> code_vld);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld |-> $stable({fld, vblk, hsync}));

    p_code_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> !code_vld);

    p_code_src_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> $past(smp_vld));

    p_msb_zero_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !bad_strobe) |-> $past(smp_data[DW-1]));

    p_clean_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !fix_strobe && !bad_strobe) |->
            ({fld, vblk, hsync} == $past(smp_data[DW-2 -: 3])));

endmodule

bind vid_trc_decode vid_trc_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .smp_data   (smp_data),
    .code_vld   (code_vld),
    .fld        (fld),
    .vblk       (vblk),
    .hsync      (hsync),
    .fix_strobe (fix_strobe),
    .bad_strobe (bad_strobe)
);

// File: tb/tb_vid_trc_decode.sv
`timescale 1ns/1ps
module tb_vid_trc_decode;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_data = 8'h55;
    logic       code_vld, fld, vblk, hsync, is_eav, fix_strobe, bad_strobe;

    int total = 0;
    int bad = 0;
    int unexpected = 0;
    bit done = 1'b0;

    typedef struct {
        logic  f, v, h, fix, err;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    vid_trc_decode dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .code_vld(code_vld), .fld(fld), .vblk(vblk), .hsync(hsync),
        .is_eav(is_eav), .fix_strobe(fix_strobe), .bad_strobe(bad_strobe)
    );

    // R2 layout: 1 F V H (V^H) (F^H) (F^V) (F^V^H)
    function automatic logic [7:0] mk_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic put(input logic [7:0] d, input int gap);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk); smp_vld = 1'b0; smp_data = 8'h5A;
        end
        @(negedge clk); smp_vld = 1'b1; smp_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_vld = 1'b0; smp_data = 8'h33;
        end
    endtask

    task automatic send(input logic f, input logic v, input logic h, input logic [7:0] mask,
                        input bit lead_ff, input int gap, input string tag);
        logic [7:0] w;
        exp_t e;
        int n;
        w = mk_word(f, v, h) ^ mask;
        n = $countones(mask[6:0]);
        e.tag = tag;
        if (mask[7] || n >= 2) begin
            e.f = w[6]; e.v = w[5]; e.h = w[4]; e.fix = 1'b0; e.err = 1'b1;
        end else begin
            e.f = f; e.v = v; e.h = h; e.fix = (n == 1); e.err = 1'b0;
        end
        if (lead_ff) put(8'hFF, gap);
        put(8'hFF, gap);
        put(8'h00, gap);
        put(8'h00, gap);
        sb.push_back(e);
        put(w, gap);
        idle(1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && code_vld) begin
            if (sb.size() == 0) begin
                unexpected++;
            end else begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if ({fld, vblk, hsync, is_eav, fix_strobe, bad_strobe} !==
                    {e.f, e.v, e.h, e.h, e.fix, e.err}) begin
                    bad++;
                    $display("FAIL %s: got fvh=%b%b%b eav=%b fix=%b bad=%b exp fvh=%b%b%b eav=%b fix=%b bad=%b",
                             e.tag, fld, vblk, hsync, is_eav, fix_strobe, bad_strobe,
                             e.f, e.v, e.h, e.h, e.fix, e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        total++;
        if ({code_vld, fld, vblk, hsync, fix_strobe, bad_strobe} !== 6'b0) begin
            bad++;
            $display("FAIL R9 reset: got %b exp 000000",
                     {code_vld, fld, vblk, hsync, fix_strobe, bad_strobe});
        end

        // R3 / R8: all clean flag combinations
        for (int k = 0; k < 8; k++)
            send(k[2], k[1], k[0], 8'h00, 1'b0, 0, "R3_R8 clean");

        // R4: single flag flips
        for (int b = 4; b < 7; b++) begin
            send(1'b1, 1'b0, 1'b1, 8'(1 << b), 1'b0, 0, "R4 flag flip");
            send(1'b0, 1'b1, 1'b0, 8'(1 << b), 1'b0, 0, "R4 flag flip");
        end
        // R5: single protection bit flips
        for (int b = 0; b < 4; b++)
            send(1'b0, 1'b1, 1'b1, 8'(1 << b), 1'b0, 0, "R5 parity flip");

        // R6: double errors
        send(1'b0, 1'b0, 1'b0, 8'h60, 1'b0, 0, "R6 F+V");
        send(1'b1, 1'b1, 1'b0, 8'h11, 1'b0, 0, "R6 H+P0");
        send(1'b1, 1'b0, 1'b0, 8'h0C, 1'b0, 0, "R6 P3+P2");
        send(1'b0, 1'b1, 1'b1, 8'h48, 1'b0, 0, "R6 F+P3");
        send(1'b1, 1'b1, 1'b1, 8'h41, 1'b0, 0, "R6 F+P0");

        // R7: msb cleared
        send(1'b0, 1'b1, 1'b1, 8'h80, 1'b0, 0, "R7 msb zero");
        send(1'b1, 1'b0, 1'b1, 8'h81, 1'b0, 0, "R7 msb zero+P0");

        // R1 gaps and R11 repeated ones
        send(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 2, "R1 gapped preamble");
        send(1'b0, 1'b0, 1'b1, 8'h20, 1'b1, 0, "R11 double FF");
        send(1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1, "R11_R1 double FF gapped");

        // R9 / R1: broken preambles and bare status word must not touch flags (1,0,1)
        put(8'hFF, 0); put(8'h00, 0); put(8'h55, 0); put(8'h00, 0); put(8'h00, 0);
        put(mk_word(1'b0, 1'b1, 1'b0), 0);
        put(8'h00, 0); put(8'h00, 0); put(mk_word(1'b0, 1'b1, 1'b0), 0);
        put(8'hFF, 0); put(8'h00, 0); put(8'h12, 0); put(mk_word(1'b0, 1'b1, 1'b0), 0);
        idle(3);
        total++;
        if ({fld, vblk, hsync} !== 3'b101) begin
            bad++;
            $display("FAIL R9 hold: got fvh=%b%b%b exp fvh=101", fld, vblk, hsync);
        end
        total++;
        if (unexpected != 0 || sb.size() != 0) begin
            bad++;
            $display("FAIL R1 code count: got unexpected=%0d pending=%0d exp 0 and 0",
                     unexpected, sb.size());
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule